// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

This block forms the product y = A·x of a square signed-integer matrix and a vector on a linear chain of multiply-accumulate cells. Each cell owns one vector element for the whole run. A partial sum enters at the first cell, gains one product per cell, and moves one cell further on each clock. Matrix entries arrive on one lane per cell, with a diagonal skew: the entry of row i, column j reaches cell j one step later than the entry of row i, column j-1. Once the chain is full, one finished result leaves the last cell on every clock.

A run has three phases. The vector is first written into the cells through an indexed write port. A start pulse then opens the schedule, and the source drives the skewed matrix lanes for 2N-1 steps. The results then stream out with their row index, and a one-cycle done flag closes the run.

Top module: `mvSystolic`

## Requirements
- R1: While reset is asserted and after it is released, yValid and done are 0 and yData is 0.
- R2: A vector write (vecWe high while idle) stores vecData as x(vecIdx+1). The cell keeps that value for the whole run, and a vector write made while a run is in progress has no effect on that run or on later runs.
- R3: The edge that samples start high while idle opens a run. Step s is the s-th rising edge after that one. On step s, lane j (data bits [8j+7:8j], j counted from 0) is sampled as the entry of row s-1-j (counted from 0) for every row index in range.
- R4: Each result is the exact signed sum over j of a(i,j)·x(j), using 8-bit signed operands and a 20-bit signed result, with no overflow even at -128·-128 for every term.
- R5: After step N+i-1 (i = 1..N), yValid is 1, yIdx is i-1 and yData is y(i). yValid is 1 for exactly N consecutive cycles per run and is 0 after steps 1..N-1.
- R6: A lane whose laneValid bit is 0 on a step adds zero to the sum, whatever its data bits hold.
- R7: done is 1 for exactly the one cycle after the last result (after step 2N), and yValid is 0 in that cycle.
- R8: A start pulse during a run is ignored, and the schedule and results of that run do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| vecWe | input | 1 | Vector element write strobe |
| vecIdx | input | 2 | Vector element index, counted from 0 |
| vecData | input | 8 | Signed vector element |
| start | input | 1 | Starts a run when idle |
| laneData | input | 32 | Matrix lanes, 8 bits per cell, lane 0 in the low byte |
| laneValid | input | 4 | Per-lane valid; a lane with valid low counts as zero |
| yData | output | 20 | Signed result element |
| yValid | output | 1 | yData holds a result |
| yIdx | output | 2 | Row index of yData, counted from 0 |
| done | output | 1 | One-cycle pulse after the last result of a run |

## Verification
Suppose one cell held a wrong vector element or dropped a product. Every row result from that run would then be wrong in a fixed pattern, and the first bad value would show on yData as soon as the first result comes out, N edges after start. A step counter that is off by one moves the whole valid window and the done pulse by a cycle. It also makes the lanes line up with the wrong rows, so the run would miscompare on the first result, the last result and the cycle checked for done. A stale partial sum or a lane that was not masked shows up as a fixed offset in one row only, and only on the row whose schedule touched it. Extreme operands make a sign or width fault visible on the first result.

// File: rtl/mvPkg.sv
package mvPkg;
  // strobes from sequencing control to the arithmetic datapath
  typedef struct packed {
    logic advance;  // cells perform one multiply-add this edge
    logic vecWrOk;  // vector write accepted this edge
  } mvStrobeT;
endpackage

// File: rtl/mvCell.sv
module mvCell #(
  parameter int DW = 8,
  parameter int SW = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 advance,
  input  logic signed [DW-1:0] aIn,
  input  logic signed [DW-1:0] xIn,
  input  logic signed [SW-1:0] psIn,
  output logic signed [SW-1:0] psOut
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] prodExt;

  always_comb begin
    prod    = aIn * xIn;
    prodExt = {{(SW-PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (!rstN)        psOut <= '0;
    else if (advance) psOut <= psIn + prodExt;
  end
endmodule

// File: rtl/mvCtrl.sv
module mvCtrl
  import mvPkg::*;
#(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 vecWe,
  output mvStrobeT             strb,
  output logic                 yValid,
  output logic [$clog2(N)-1:0] yIdx,
  output logic                 done
);
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(2 * N + 1);
  localparam logic [CW-1:0] FIRST_OUT = CW'(N);
  localparam logic [CW-1:0] LAST_STEP = CW'(2 * N - 1);
  localparam logic [CW-1:0] END_STEP  = CW'(2 * N);

  logic          running;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strb.advance = running && (stepCnt <= LAST_STEP);
    strb.vecWrOk = !running && vecWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      stepCnt <= '0;
      yValid  <= 1'b0;
      yIdx    <= '0;
      done    <= 1'b0;
    end else begin
      yValid <= 1'b0;
      done   <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          stepCnt <= CW'(1);
        end
      end else begin
        if (stepCnt == END_STEP) begin
          running <= 1'b0;
          stepCnt <= '0;
          done    <= 1'b1;
        end else begin
          stepCnt <= stepCnt + CW'(1);
        end
        if (stepCnt >= FIRST_OUT && stepCnt <= LAST_STEP) begin
          yValid <= 1'b1;
          yIdx   <= IW'(stepCnt - FIRST_OUT);
        end
      end
    end
  end
endmodule

// File: rtl/mvDatapath.sv
module mvDatapath
  import mvPkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int SW = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mvStrobeT             strb,
  input  logic [$clog2(N)-1:0] vecIdx,
  input  logic [DW-1:0]        vecData,
  input  logic [N*DW-1:0]      laneData,
  input  logic [N-1:0]         laneValid,
  output logic signed [SW-1:0] yData
);
  logic signed [DW-1:0] xReg  [N];
  logic signed [DW-1:0] aLane [N];
  logic signed [SW-1:0] psum  [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < N; k++) xReg[k] <= '0;
    end else if (strb.vecWrOk) begin
      xReg[vecIdx] <= vecData;
    end
  end

  for (genvar j = 0; j < N; j++) begin : gCell
    assign aLane[j] = laneValid[j] ? laneData[j*DW +: DW] : '0;

    logic signed [SW-1:0] psIn;
    if (j == 0) begin : gHead
      assign psIn = '0;
    end else begin : gLink
      assign psIn = psum[j-1];
    end

    mvCell #(.DW(DW), .SW(SW)) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .advance (strb.advance),
      .aIn     (aLane[j]),
      .xIn     (xReg[j]),
      .psIn    (psIn),
      .psOut   (psum[j])
    );
  end

  assign yData = psum[N-1];
endmodule

// File: rtl/mvSystolic.sv
module mvSystolic
  import mvPkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int SW = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 vecWe,
  input  logic [$clog2(N)-1:0] vecIdx,
  input  logic [DW-1:0]        vecData,
  input  logic                 start,
  input  logic [N*DW-1:0]      laneData,
  input  logic [N-1:0]         laneValid,
  output logic signed [SW-1:0] yData,
  output logic                 yValid,
  output logic [$clog2(N)-1:0] yIdx,
  output logic                 done
);
  mvStrobeT strb;

  mvCtrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .vecWe  (vecWe),
    .strb   (strb),
    .yValid (yValid),
    .yIdx   (yIdx),
    .done   (done)
  );

  mvDatapath #(.N(N), .DW(DW), .SW(SW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .vecIdx    (vecIdx),
    .vecData   (vecData),
    .laneData  (laneData),
    .laneValid (laneValid),
    .yData     (yData)
  );
endmodule

// File: rtl/mvSystolicChk.sv
module mvSystolicChk #(
  parameter int N = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 yValid,
  input logic [$clog2(N)-1:0] yIdx,
  input logic                 done
);
  localparam int IW = $clog2(N);

  // R5: a result burst opens with row 0
  a_r5_first_row: assert property (@(posedge clk) disable iff (!rstN)
    $rose(yValid) |-> (yIdx == '0));

  // R5: consecutive results carry consecutive row indices
  a_r5_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (yValid && $past(yValid)) |-> (yIdx == IW'($past(yIdx) + 1'b1)));

  // R5: a burst only ends after the last row
  a_r5_burst_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(yValid) |-> ($past(yIdx) == IW'(N - 1)));

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: done directly follows the last row and never overlaps a result
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!yValid && $past(yValid) && ($past(yIdx) == IW'(N - 1))));
endmodule

bind mvSystolic mvSystolicChk #(.N(N)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .yValid (yValid),
  .yIdx   (yIdx),
  .done   (done)
);

// File: tb/mvSystolic_bench.sv
module mvSystolic_bench;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int SW = 20;
  localparam int VW = N * N * DW + N * DW;

  // matrix entry (i,j) at byte i*N+j; vector element j at byte N*N+j
  localparam logic [VW-1:0] VECS [4] = '{
    {32'h04030201, 128'h01000000_00010000_00000100_00000001},
    {32'h80808080, {16{8'h80}}},
    {32'h80808080, {16{8'h7F}}},
    {32'hFF807F05, 128'hF31205FE_7F800100_C04011EE_09F733CC}
  };

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 vecWe = 1'b0;
  logic [1:0]           vecIdx = '0;
  logic [DW-1:0]        vecData = '0;
  logic                 start = 1'b0;
  logic [N*DW-1:0]      laneData = '0;
  logic [N-1:0]         laneValid = '0;
  logic signed [SW-1:0] yData;
  logic                 yValid;
  logic [1:0]           yIdx;
  logic                 done;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mvSystolic #(.N(N), .DW(DW), .SW(SW)) u_mvSystolic (
    .clk(clk), .rstN(rstN), .vecWe(vecWe), .vecIdx(vecIdx), .vecData(vecData),
    .start(start), .laneData(laneData), .laneValid(laneValid),
    .yData(yData), .yValid(yValid), .yIdx(yIdx), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  function automatic int elemA(input logic [VW-1:0] v, input int i, input int j);
    return int'($signed(v[(i*N+j)*DW +: DW]));
  endfunction

  function automatic int elemX(input logic [VW-1:0] v, input int j);
    return int'($signed(v[(N*N+j)*DW +: DW]));
  endfunction

  task automatic loadX(input logic [VW-1:0] v);
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      vecWe = 1'b1; vecIdx = 2'(j); vecData = v[(N*N+j)*DW +: DW];
    end
    @(negedge clk);
    vecWe = 1'b0;
  endtask

  task automatic runVec(input logic [VW-1:0] v, input bit doLoad, input bit midStart,
                        input bit midWrite, input int dropI, input int dropJ, input string tag);
    int yExp [N];
    if (doLoad) loadX(v);
    for (int i = 0; i < N; i++) begin
      yExp[i] = 0;
      for (int j = 0; j < N; j++)
        if (!(i == dropI && j == dropJ)) yExp[i] += elemA(v, i, j) * elemX(v, j);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int s = 1; s <= 2*N-1; s++) begin
      start   = midStart && (s == 2);          // R8 stimulus
      vecWe   = midWrite && (s == 3);          // R2 stimulus
      vecIdx  = 2'd0;
      vecData = 8'h55;
      for (int j = 0; j < N; j++) begin
        int i;
        i = s - 1 - j;                          // R3 skew
        if (i >= 0 && i < N) begin
          laneData[j*DW +: DW] = v[(i*N+j)*DW +: DW];
          laneValid[j] = !(i == dropI && j == dropJ);
        end else begin
          laneData[j*DW +: DW] = 8'hA5 ^ 8'(s); // R6: junk on idle lanes
          laneValid[j] = 1'b0;
        end
      end
      @(negedge clk);
      if (s >= N) begin
        chk(yValid && (int'(yIdx) == s - N), "R5", {tag, " valid/index"},
            longint'(yIdx) + (yValid ? 0 : 100), s - N);
        chk(int'(yData) == yExp[s-N], "R4", {tag, " result"}, yData, yExp[s-N]);
      end else begin
        chk(!yValid && !done, "R5", {tag, " early quiet"}, yValid, 0);
      end
    end
    start = 1'b0; vecWe = 1'b0; laneValid = '0;
    @(negedge clk);
    chk(done && !yValid, "R7", {tag, " done pulse"}, {yValid, done}, 1);
    @(negedge clk);
    chk(!done, "R7", {tag, " done drop"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!yValid && !done && yData == 0, "R1", "in reset", {yValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!yValid && !done && yData == 0, "R1", "after reset", yData, 0);

    // table walk: R3, R4, R5, R6, R7
    for (int k = 0; k < 4; k++) runVec(VECS[k], 1'b1, 1'b0, 1'b0, -1, -1, "table");

    // R8: start mid-run ignored
    runVec(VECS[3], 1'b1, 1'b1, 1'b0, -1, -1, "R8 midstart");
    // R2: vector write mid-run ignored, then a run without reload still uses old x
    runVec(VECS[3], 1'b1, 1'b0, 1'b1, -1, -1, "R2 midwrite");
    runVec(VECS[3], 1'b0, 1'b0, 1'b0, -1, -1, "R2 retained");
    // R6: scheduled entry with valid low counts as zero (a(1,2) = 0x33)
    runVec(VECS[3], 1'b0, 1'b0, 1'b0, 0, 1, "R6 masked");

    summary();
  end
endmodule